// File: doc/BRIEF.md
# Network Command Flit Deserializer

This block sits in front of a memory-mapped target. It takes 40-bit command flits from the on-chip network and rebuilds them as VCI command words. The first two flits of every packet are header flits. Two flag bits decide the packet kind: bit 0 of the first flit and the end-of-packet bit (bit 39) of the second flit. No length field is used.

A unicast read becomes one VCI word. A unicast write becomes one VCI word for each data flit. A broadcast becomes one write word. The header fields are captured once per packet and repeated on every word the packet produces. The VCI end-of-packet flag is raised on the last word.

Flits arrive on a valid/ready stream. Back-pressure rules:
- A flit that produces a VCI word is presented on the command side in the same cycle. It is taken only when the target acknowledges that word.
- Header flits that produce nothing, and flits that are dropped, are always taken at once.
- The command valid never depends on the acknowledge.

A sticky error flag records a malformed packet. The parser then returns to waiting for a first flit.

Top module: `cmd_flit_deser`

## Requirements
- R1: Bit 0 of the first flit selects a broadcast (1) or a unicast (0) packet. A first flit never produces a VCI word.
- R2: In a unicast packet, first-flit bits 38:1 are a word address. Every word of the packet carries the byte address {bits 38:1, 2'b00}.
- R3: The unicast second flit carries these header fields:
  - source id in bits 38:25
  - command code in 24:23
  - ordering bits in 22:21
  - length in 20:13
  - transaction id in 12:9
  - packet id in 8:5
  Every word of the packet repeats these fields unchanged.
- R4: A unicast second flit with bit 39 = 1 is a read. It produces exactly one word with eop=1, byte-enable 4'hF and write data 0.
- R5: A unicast second flit with bit 39 = 0 produces no word. Each following data flit produces one word, with byte-enable from bits 35:32, write data from bits 31:0 and eop equal to its bit 39. The flit with bit 39 = 1 ends the packet.
- R6: Broadcast first-flit layout:
  - source X in bits 38:34 and source Y in 33:29
  - transaction id in 28:25 and packet id in 24:21
  - box fields X-min 20:16, X-max 15:11, Y-min 10:6, Y-max 5:1

  Its second flit has bit 39 = 1 and carries a 34-bit line number in bits 33:0. It produces one word with:
  - command 2'b10 (write), bcast=1, eop=1, byte-enable 4'hF, ordering bits 0, length 4
  - source id {X, Y, 4'b0000}
  - write data equal to line bits 31:0
  - address {16'b0, line bits 33:32, X-min, X-max, Y-min, Y-max, 2'b11}
- R7: flit_ready is low only while a word is presented and cmd_ack is low. cmd_val is high exactly when the current flit produces a word.
- R8: These flits are consumed without producing a word, set the sticky err_flag, and return the parser to first-flit state:
  - a first flit with bit 39 = 1
  - a broadcast second flit with bit 39 = 0

  err_flag stays set until reset.
- R9: After reset the parser waits for a first flit, err_flag is 0 and cmd_val is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flit_valid | input | 1 | Flit stream valid |
| flit_ready | output | 1 | Flit stream ready |
| flit_data | input | 40 | Flit, bit 39 is end-of-packet |
| cmd_val | output | 1 | VCI command valid |
| cmd_ack | input | 1 | VCI command acknowledge |
| cmd_address | output | 40 | Byte address |
| cmd_cmd | output | 2 | VCI command code |
| cmd_wdata | output | 32 | Write data |
| cmd_be | output | 4 | Byte enables |
| cmd_srcid | output | 14 | Source id |
| cmd_cst | output | 2 | Ordering bits |
| cmd_plen | output | 8 | Packet length |
| cmd_trdid | output | 4 | Transaction id |
| cmd_pktid | output | 4 | Packet id |
| cmd_eop | output | 1 | Last word of the packet |
| cmd_bcast | output | 1 | Word comes from a broadcast packet |
| err_flag | output | 1 | Sticky malformed-packet flag |

## Verification
The assertions check the handshake on every cycle:
- a flit is never taken while its word is stalled
- no word appears without a flit behind it
- a first flit never produces a word
- broadcast words carry the 2'b11 low address bits and eop
- unicast words are word aligned
- the error flag is set by a bad first flit and never clears

The field mapping needs the bench's scenarios. That covers header replay across several data flits, byte-enable and data placement, and the broadcast box and line packing. Recovery after a malformed packet is shown by a good packet that follows it. The bench also varies the acknowledge pattern.

// File: rtl/cmd_deser_pkg.sv
package cmd_deser_pkg;
  localparam int FLIT_W  = 40;
  localparam int EOP_BIT = FLIT_W - 1;
  localparam int ADDR_W  = 40;
  localparam int WADDR_W = ADDR_W - 2;
  localparam int DATA_W  = 32;
  localparam int BE_W    = DATA_W / 8;
  localparam int COORD_W = 5;
  localparam int LID_W   = 4;
  localparam int SRCID_W = 2 * COORD_W + LID_W;
  localparam int BOX_W   = 4 * COORD_W;
  localparam int LINE_W  = 34;

  localparam logic [1:0] VCMD_WRITE = 2'b10;

  typedef enum logic [1:0] {PS_HEAD0, PS_HEAD1, PS_DATA} parse_state_t;

  typedef struct packed {
    logic [SRCID_W-1:0] srcid;
    logic [1:0]         cmd;
    logic [1:0]         cst;
    logic [7:0]         plen;
    logic [3:0]         trdid;
    logic [3:0]         pktid;
  } hdr_t;

  typedef struct packed {
    logic [ADDR_W-1:0] address;
    logic [DATA_W-1:0] wdata;
    logic [BE_W-1:0]   be;
    hdr_t              hdr;
    logic              eop;
    logic              bcast;
  } vci_word_t;

  function automatic hdr_t unpack_hdr(input logic [FLIT_W-1:0] f);
    hdr_t h;
    h.srcid = f[38:25];
    h.cmd   = f[24:23];
    h.cst   = f[22:21];
    h.plen  = f[20:13];
    h.trdid = f[12:9];
    h.pktid = f[8:5];
    return h;
  endfunction
endpackage

// File: rtl/cmd_flit_parser.sv
module cmd_flit_parser
  import cmd_deser_pkg::*;
#(
  parameter logic [7:0] BCAST_PLEN = 8'd4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fire,
  input  logic [FLIT_W-1:0]   flit,
  output parse_state_t        state,
  output logic                bc_q,
  output logic [ADDR_W-1:0]   addr_q,
  output hdr_t                hdr_q,
  output logic [BOX_W-1:0]    box_q,
  output logic                err_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= PS_HEAD0;
      bc_q   <= 1'b0;
      addr_q <= '0;
      hdr_q  <= '0;
      box_q  <= '0;
      err_q  <= 1'b0;
    end else if (fire) begin
      unique case (state)
        PS_HEAD0: begin
          if (flit[EOP_BIT]) begin
            err_q <= 1'b1;
          end else begin
            bc_q  <= flit[0];
            state <= PS_HEAD1;
            if (flit[0]) begin
              hdr_q.srcid <= {flit[38:29], {LID_W{1'b0}}};
              hdr_q.cmd   <= VCMD_WRITE;
              hdr_q.cst   <= 2'b00;
              hdr_q.plen  <= BCAST_PLEN;
              hdr_q.trdid <= flit[28:25];
              hdr_q.pktid <= flit[24:21];
              box_q       <= flit[BOX_W:1];
            end else begin
              addr_q <= {flit[WADDR_W:1], 2'b00};
            end
          end
        end
        PS_HEAD1: begin
          if (bc_q) begin
            if (!flit[EOP_BIT]) err_q <= 1'b1;
            state <= PS_HEAD0;
          end else begin
            hdr_q <= unpack_hdr(flit);
            state <= flit[EOP_BIT] ? PS_HEAD0 : PS_DATA;
          end
        end
        PS_DATA: begin
          if (flit[EOP_BIT]) state <= PS_HEAD0;
        end
        default: state <= PS_HEAD0;
      endcase
    end
  end
endmodule

// File: rtl/cmd_word_builder.sv
module cmd_word_builder
  import cmd_deser_pkg::*;
(
  input  parse_state_t       state,
  input  logic               flit_valid,
  input  logic [FLIT_W-1:0]  flit,
  input  logic               bc_q,
  input  logic [ADDR_W-1:0]  addr_q,
  input  hdr_t               hdr_q,
  input  logic [BOX_W-1:0]   box_q,
  output logic               word_val,
  output vci_word_t          word
);
  localparam int PAD_W = ADDR_W - 2 - BOX_W - (LINE_W - DATA_W);

  always_comb begin
    word     = '0;
    word_val = 1'b0;
    unique case (state)
      PS_HEAD1: begin
        if (flit[EOP_BIT]) begin
          word_val = flit_valid;
          word.eop = 1'b1;
          word.be  = {BE_W{1'b1}};
          if (bc_q) begin
            word.bcast   = 1'b1;
            word.hdr     = hdr_q;
            word.wdata   = flit[DATA_W-1:0];
            word.address = {{PAD_W{1'b0}}, flit[LINE_W-1:DATA_W], box_q, 2'b11};
          end else begin
            word.hdr     = unpack_hdr(flit);
            word.address = addr_q;
          end
        end
      end
      PS_DATA: begin
        word_val     = flit_valid;
        word.eop     = flit[EOP_BIT];
        word.be      = flit[DATA_W+BE_W-1:DATA_W];
        word.wdata   = flit[DATA_W-1:0];
        word.hdr     = hdr_q;
        word.address = addr_q;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cmd_flit_deser.sv
module cmd_flit_deser
  import cmd_deser_pkg::*;
#(
  parameter logic [7:0] BCAST_PLEN = 8'd4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flit_valid,
  output logic         flit_ready,
  input  logic [39:0]  flit_data,
  output logic         cmd_val,
  input  logic         cmd_ack,
  output logic [39:0]  cmd_address,
  output logic [1:0]   cmd_cmd,
  output logic [31:0]  cmd_wdata,
  output logic [3:0]   cmd_be,
  output logic [13:0]  cmd_srcid,
  output logic [1:0]   cmd_cst,
  output logic [7:0]   cmd_plen,
  output logic [3:0]   cmd_trdid,
  output logic [3:0]   cmd_pktid,
  output logic         cmd_eop,
  output logic         cmd_bcast,
  output logic         err_flag
);
  parse_state_t      state;
  logic              bc_q;
  logic [ADDR_W-1:0] addr_q;
  hdr_t              hdr_q;
  logic [BOX_W-1:0]  box_q;
  logic              word_val;
  vci_word_t         word;
  logic              fire;

  assign flit_ready = !word_val || cmd_ack;
  assign fire       = flit_valid && flit_ready;

  cmd_flit_parser #(.BCAST_PLEN(BCAST_PLEN)) u_parser (
    .clk(clk), .rst_n(rst_n), .fire(fire), .flit(flit_data),
    .state(state), .bc_q(bc_q), .addr_q(addr_q), .hdr_q(hdr_q),
    .box_q(box_q), .err_q(err_flag)
  );

  cmd_word_builder u_builder (
    .state(state), .flit_valid(flit_valid), .flit(flit_data),
    .bc_q(bc_q), .addr_q(addr_q), .hdr_q(hdr_q), .box_q(box_q),
    .word_val(word_val), .word(word)
  );

  assign cmd_val     = word_val;
  assign cmd_address = word.address;
  assign cmd_cmd     = word.hdr.cmd;
  assign cmd_wdata   = word.wdata;
  assign cmd_be      = word.be;
  assign cmd_srcid   = word.hdr.srcid;
  assign cmd_cst     = word.hdr.cst;
  assign cmd_plen    = word.hdr.plen;
  assign cmd_trdid   = word.hdr.trdid;
  assign cmd_pktid   = word.hdr.pktid;
  assign cmd_eop     = word.eop;
  assign cmd_bcast   = word.bcast;
endmodule

// File: rtl/cmd_deser_chk.sv
module cmd_deser_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        flit_valid,
  input logic        flit_ready,
  input logic [39:0] flit_data,
  input logic        cmd_val,
  input logic        cmd_ack,
  input logic [39:0] cmd_address,
  input logic        cmd_eop,
  input logic        cmd_bcast,
  input logic        err_flag
);
  logic at_start;
  always_ff @(posedge clk) begin
    if (!rst_n) at_start <= 1'b1;
    else if (flit_valid && flit_ready) at_start <= flit_data[39];
  end

  a_r7_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_val && !cmd_ack |-> !flit_ready);
  a_r7_val_needs_flit: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_val |-> flit_valid);
  a_r1_no_word_on_first: assert property (@(posedge clk) disable iff (!rst_n)
    at_start |-> !cmd_val);
  a_r6_bcast_form: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_val && cmd_bcast |-> cmd_eop && cmd_address[1:0] == 2'b11);
  a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_val && !cmd_bcast |-> cmd_address[1:0] == 2'b00);
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);
  a_r8_bad_first_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
    flit_valid && flit_ready && at_start && flit_data[39] |=> err_flag);
endmodule

bind cmd_flit_deser cmd_deser_chk u_chk (
  .clk(clk), .rst_n(rst_n), .flit_valid(flit_valid), .flit_ready(flit_ready),
  .flit_data(flit_data), .cmd_val(cmd_val), .cmd_ack(cmd_ack),
  .cmd_address(cmd_address), .cmd_eop(cmd_eop), .cmd_bcast(cmd_bcast),
  .err_flag(err_flag)
);

// File: tb/cmd_flit_deser_tb_top.sv
module cmd_flit_deser_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flit_valid = 1'b0;
  logic [39:0] flit_data = '0;
  logic cmd_ack = 1'b0;
  logic flit_ready, cmd_val, cmd_eop, cmd_bcast, err_flag;
  logic [39:0] cmd_address;
  logic [1:0] cmd_cmd, cmd_cst;
  logic [31:0] cmd_wdata;
  logic [3:0] cmd_be, cmd_trdid, cmd_pktid;
  logic [13:0] cmd_srcid;
  logic [7:0] cmd_plen;

  always #5 clk = ~clk;

  cmd_flit_deser dut_i (.*);

  integer n_cmp = 0, n_bad = 0, ack_mode = 0;
  bit done = 0;
  logic [111:0] exp_q[$];
  string tag_q[$];
  logic emit_exp = 0, err_exp = 0;
  integer m_state = 0;
  logic m_bc = 0;
  logic [39:0] m_addr = '0;
  logic [13:0] m_src = '0;
  logic [1:0] m_cmd = '0, m_cst = '0;
  logic [7:0] m_plen = '0;
  logic [3:0] m_trd = '0, m_pkt = '0;
  logic [19:0] m_box = '0;

  task automatic chk(input bit ok, input string tag, input logic [111:0] act, input logic [111:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [111:0] pack_w(logic [39:0] a, logic [1:0] c, logic [31:0] d, logic [3:0] be,
      logic [13:0] s, logic [1:0] cs, logic [7:0] pl, logic [3:0] t, logic [3:0] p, logic e, logic b);
    return {a, c, d, be, s, cs, pl, t, p, e, b};
  endfunction

  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk(cmd_val == (flit_valid && emit_exp), "R7 cmd_val", {111'b0, cmd_val}, {111'b0, flit_valid && emit_exp});
      if (cmd_val) chk(flit_ready == cmd_ack, "R7 ready follows ack", {111'b0, flit_ready}, {111'b0, cmd_ack});
      else if (flit_valid) chk(flit_ready, "R7 ready when no word", {111'b0, flit_ready}, 112'd1);
      if (cmd_val && cmd_ack) begin
        logic [111:0] act;
        act = pack_w(cmd_address, cmd_cmd, cmd_wdata, cmd_be, cmd_srcid, cmd_cst,
                     cmd_plen, cmd_trdid, cmd_pktid, cmd_eop, cmd_bcast);
        if (exp_q.size() == 0) chk(1'b0, "R7 unexpected word", act, '0);
        else begin
          logic [111:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(act == e, t, act, e);
        end
      end
      chk(err_flag == err_exp, "R8 err_flag", {111'b0, err_flag}, {111'b0, err_exp});
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      case (ack_mode)
        0: cmd_ack = ($urandom % 4) != 0;
        1: cmd_ack = 1'b1;
        default: cmd_ack = 1'b0;
      endcase
    end
  end

  task automatic send(input logic [39:0] f);
    logic acc, bad;
    logic [111:0] w;
    string t;
    bad = 0; emit_exp = 0; w = '0; t = "";
    case (m_state)
      0: bad = f[39];
      1: if (m_bc) begin
           if (f[39]) begin
             emit_exp = 1; t = "R6 broadcast word";
             w = pack_w({16'b0, f[33:32], m_box, 2'b11}, 2'b10, f[31:0], 4'hF,
                        m_src, 2'b00, 8'd4, m_trd, m_pkt, 1'b1, 1'b1);
           end else bad = 1;
         end else if (f[39]) begin
           emit_exp = 1; t = "R4 read word (R2 R3)";
           w = pack_w(m_addr, f[24:23], 32'h0, 4'hF, f[38:25], f[22:21], f[20:13],
                      f[12:9], f[8:5], 1'b1, 1'b0);
         end
      default: begin
        emit_exp = 1; t = "R5 write word (R2 R3)";
        w = pack_w(m_addr, m_cmd, f[31:0], f[35:32], m_src, m_cst, m_plen, m_trd, m_pkt, f[39], 1'b0);
      end
    endcase
    if (emit_exp) begin exp_q.push_back(w); tag_q.push_back(t); end
    flit_valid = 1'b1;
    flit_data  = f;
    forever begin
      #1 acc = flit_ready;
      @(posedge clk);
      if (acc) begin
        if (bad) err_exp = 1'b1;
        case (m_state)
          0: if (!f[39]) begin
               m_bc = f[0]; m_state = 1;
               if (f[0]) begin
                 m_src = {f[38:29], 4'b0}; m_trd = f[28:25]; m_pkt = f[24:21]; m_box = f[20:1];
               end else m_addr = {f[38:1], 2'b00};
             end
          1: if (m_bc) m_state = 0;
             else begin
               m_src = f[38:25]; m_cmd = f[24:23]; m_cst = f[22:21]; m_plen = f[20:13];
               m_trd = f[12:9]; m_pkt = f[8:5];
               m_state = f[39] ? 0 : 2;
             end
          default: if (f[39]) m_state = 0;
        endcase
      end
      @(negedge clk);
      if (acc) break;
    end
    flit_valid = 1'b0;
    emit_exp = 0;
  endtask

  function automatic logic [39:0] f_u0(logic [37:0] a); return {1'b0, a, 1'b0}; endfunction
  function automatic logic [39:0] f_hd(logic e, logic [13:0] s, logic [1:0] c, logic [1:0] cs,
      logic [7:0] pl, logic [3:0] t, logic [3:0] p);
    return {e, s, c, cs, pl, t, p, 5'b10101};
  endfunction
  function automatic logic [39:0] f_dt(logic e, logic [3:0] be, logic [31:0] d); return {e, 3'b111, be, d}; endfunction
  function automatic logic [39:0] f_b0(logic [4:0] x, logic [4:0] y, logic [3:0] t, logic [3:0] p, logic [19:0] box);
    return {1'b0, x, y, t, p, box, 1'b1};
  endfunction
  function automatic logic [39:0] f_b1(logic e, logic [33:0] ln); return {e, 5'b11011, ln}; endfunction

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk(!cmd_val, "R9 cmd_val in reset", {111'b0, cmd_val}, '0);
    chk(!err_flag, "R9 err_flag in reset", {111'b0, err_flag}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    chk(!cmd_val && !err_flag, "R9 after reset", {110'b0, cmd_val, err_flag}, '0);
    @(negedge clk);
    // R4 read, R2 address
    send(f_u0(38'h2A_1234_5678)); send(f_hd(1, 14'h1ABC, 2'b01, 2'b10, 8'd4, 4'h3, 4'h9));
    // R5 write with one data flit, then three
    send(f_u0(38'h3F_FFFF_FFFF)); send(f_hd(0, 14'h0421, 2'b10, 2'b01, 8'd4, 4'h5, 4'h6));
    send(f_dt(1, 4'b0110, 32'hDEAD_BEEF));
    send(f_u0(38'h00_0000_0001)); send(f_hd(0, 14'h3FFF, 2'b10, 2'b11, 8'd12, 4'hA, 4'hF));
    for (int i = 0; i < 3; i++) send(f_dt(i == 2, 4'(i + 1), 32'h1000_0000 + i));
    // R6 broadcast
    send(f_b0(5'd17, 5'd3, 4'hC, 4'h2, 20'hABCDE)); send(f_b1(1, 34'h2_8765_4321));
    // stall phase on a multi-word write (R7)
    ack_mode = 2;
    send(f_u0(38'h15_5555_5555));
    fork
      begin send(f_hd(0, 14'h0001, 2'b10, 2'b00, 8'd8, 4'h1, 4'h2)); send(f_dt(0, 4'hF, 32'h0)); send(f_dt(1, 4'h8, 32'hFFFF_FFFF)); end
      begin repeat (6) @(negedge clk); ack_mode = 0; end
    join
    ack_mode = 0;
    // R8 bad first flit, then a good read must still decode
    send({1'b1, 39'h12345});
    send(f_u0(38'h01_0203_0405)); send(f_hd(1, 14'h0077, 2'b01, 2'b00, 8'd4, 4'h4, 4'h4));
    // R8 broadcast with early-missing EOP, then a write
    send(f_b0(5'd1, 5'd2, 4'h7, 4'h8, 20'h00001)); send(f_b1(0, 34'h1));
    send(f_u0(38'h0A_0B0C_0D0E)); send(f_hd(0, 14'h2222, 2'b10, 2'b01, 8'd4, 4'hE, 4'hD));
    send(f_dt(1, 4'b1001, 32'h0BAD_F00D));
    ack_mode = 1;
    for (int k = 0; k < 4; k++) begin
      send(f_b0(5'(k), 5'(31 - k), 4'(k), 4'(k + 8), 20'(k * 4099)));
      send(f_b1(1, 34'(k * 1234567)));
    end
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all words delivered", 112'(exp_q.size()), '0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog R7 actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule